// File: doc/BRIEF.md
# Rotating priority interrupt resolver

This block sits between the request latch and the processor-facing side of an eight-line interrupt controller. Each cycle it takes the pending and mask vectors, holds the in-service register and a rotation base, and decides whether to raise the interrupt output. Priority is relative to the base: priority position p belongs to line (p + base) mod N. Position 0 is the highest. A request is raised only when the best unmasked pending line sits at a strictly better position than the best line already in service.

When the processor acknowledges, the block marks the winning line in service. It returns a vector made of a programmed upper field with the line number in the low bits. An acknowledge with nothing to grant returns the lowest line number's complement, which is line N-1. Automatic end-of-interrupt and rotation on it are selectable. A special fully nested option lets the cascade line interrupt again while it is itself in service. Explicit end-of-interrupt (highest-priority or by line) and set-priority commands arrive as decoded single-cycle strobes.

All outputs are registered. A strobe applied in one cycle shows on the outputs after the next rising edge.

Top module: `irq_rot_resolver`

## Requirements
- R1: A synchronous reset clears the in-service register, the rotation base, the interrupt output and the vector-valid flag to 0.
- R2: When pending AND NOT mask is zero, the interrupt output is low in the following cycle.
- R3: Among unmasked pending lines, the winner is the one at the lowest position, where position p is line (p + base) mod 8; the same ordering ranks in-service lines.
- R4: The interrupt output is high in the cycle after the best candidate's position is strictly lower than the best in-service position (an empty in-service register counts as position 8). An equal or worse position keeps it low.
- R5: With the special fully nested input high, in-service bit 2 (the cascade line) is left out of the comparison of R4. This means a pending line 2 may interrupt while line 2 is in service.
- R6: An acknowledge with a winner and automatic end-of-interrupt off sets that line's in-service bit. In the next cycle, vector-valid is high for exactly one cycle and the vector is {vector base, line[2:0]}.
- R7: An acknowledge with no winner returns {vector base, 3'd7} and leaves the in-service register unchanged.
- R8: With automatic end-of-interrupt on, an acknowledge leaves the in-service register unchanged. If rotate-on-automatic-end-of-interrupt is also on, the base becomes (line + 1) mod 8.
- R9: The end-of-interrupt strobe clears the in-service bit at the best in-service position (the cascade bit is not exempt). With the rotate flag, it also sets the base to (that line + 1) mod 8. With nothing in service, it has no effect.
- R10: The specific end-of-interrupt strobe clears the in-service bit of the given line. With the rotate flag, it sets the base to (that line + 1) mod 8.
- R11: The set-priority strobe sets the base to (given line + 1) mod 8, making the given line the lowest priority.
- R12: When strobes meet in one cycle, clears are taken from the in-service register before the cycle, and then the acknowledge's set is applied. For the base, the acknowledge rotation takes precedence over the highest-priority end-of-interrupt rotation, which takes precedence over the specific one, which takes precedence over set-priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | 8 | Latched pending requests, one bit per line |
| mask_i | input | 8 | Mask, 1 blocks the line |
| vec_base_i | input | 5 | Upper field of the returned vector |
| auto_eoi_i | input | 1 | Automatic end-of-interrupt enable |
| rot_aeoi_i | input | 1 | Rotate base on automatic end-of-interrupt |
| sfnm_i | input | 1 | Special fully nested option for the cascade line |
| ack_i | input | 1 | Acknowledge strobe |
| eoi_i | input | 1 | End-of-interrupt strobe, highest-priority in-service line |
| spec_eoi_i | input | 1 | End-of-interrupt strobe for the line in spec_line_i |
| spec_line_i | input | 3 | Line for the specific end-of-interrupt |
| eoi_rot_i | input | 1 | Rotate flag for either end-of-interrupt strobe |
| prio_set_i | input | 1 | Set-priority strobe |
| prio_line_i | input | 3 | Line that becomes lowest priority |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector from the last acknowledge |
| vec_valid_o | output | 1 | One-cycle flag, vec_o is fresh |
| isr_o | output | 8 | In-service register |
| rot_base_o | output | 3 | Current rotation base |

## Verification
The acknowledge and an end-of-interrupt can land in the same cycle. The acknowledge may also grant the cascade line while the end-of-interrupt clears that very bit under the special fully nested option. This case is provoked with directed cycles that put line 2 in service and then pulse both strobes together. It is also provoked by random traffic in which acknowledge, both end-of-interrupt forms and set-priority fire independently. The bench model applies the clear-then-set and base precedence of R12 and compares the in-service register, base and vector each cycle.

// File: rtl/irq_rot_pkg.sv
package irq_rot_pkg;

  // Source chosen for the next rotation base, in precedence order.
  typedef enum logic [2:0] {
    BASE_HOLD = 3'd0,
    BASE_ACK  = 3'd1,
    BASE_EOI  = 3'd2,
    BASE_SEOI = 3'd3,
    BASE_PRIO = 3'd4
  } base_src_e;

endpackage

// File: rtl/irq_rot_find.sv
// Finds the best-priority set bit of a vector relative to a rotation base.
module irq_rot_find #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  input  logic [LW-1:0] base_i,
  output logic          any_o,
  output logic [LW:0]   pos_o,
  output logic [LW-1:0] line_o
);

  logic [2*N-1:0] dbl;
  logic [N-1:0]   rot;
  logic [LW:0]    pos_c;

  // rot[p] holds line (p + base) mod N
  assign dbl = {vec_i, vec_i} >> base_i;
  assign rot = dbl[N-1:0];

  always_comb begin
    pos_c = (LW+1)'(N);
    for (int p = N - 1; p >= 0; p--) begin
      if (rot[p]) pos_c = (LW+1)'(p);
    end
  end

  assign any_o  = |vec_i;
  assign pos_o  = pos_c;
  assign line_o = pos_c[LW-1:0] + base_i;

endmodule

// File: rtl/irq_rot_arb.sv
// Decides whether a candidate strictly beats the in-service level.
module irq_rot_arb #(
  parameter int N           = 8,
  parameter int LW          = $clog2(N),
  parameter int CASC_LINE   = 2,
  parameter bit CASC_MASTER = 1'b1
) (
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  mask_i,
  input  logic [N-1:0]  isr_i,
  input  logic [LW-1:0] base_i,
  input  logic          sfnm_i,
  output logic          req_o,
  output logic [LW-1:0] line_o
);

  logic [N-1:0]  cand;
  logic [N-1:0]  isr_cmp;
  logic          cand_any;
  logic [LW:0]   cand_pos;
  logic          isr_any;
  logic [LW:0]   isr_pos;
  logic [LW-1:0] isr_line;

  assign cand = pend_i & ~mask_i;

  generate
    if (CASC_MASTER) begin : g_master
      logic [N-1:0] casc_hole;
      always_comb begin
        casc_hole            = '0;
        casc_hole[CASC_LINE] = sfnm_i;
      end
      assign isr_cmp = isr_i & ~casc_hole;
    end else begin : g_slave
      logic unused_sfnm;
      assign unused_sfnm = sfnm_i;
      assign isr_cmp     = isr_i;
    end
  endgenerate

  irq_rot_find #(.N(N), .LW(LW)) u_find_cand (
    .vec_i  (cand),
    .base_i (base_i),
    .any_o  (cand_any),
    .pos_o  (cand_pos),
    .line_o (line_o)
  );

  irq_rot_find #(.N(N), .LW(LW)) u_find_isr (
    .vec_i  (isr_cmp),
    .base_i (base_i),
    .any_o  (isr_any),
    .pos_o  (isr_pos),
    .line_o (isr_line)
  );

  logic unused_isr;
  assign unused_isr = isr_any ^ (|isr_line);

  assign req_o = cand_any && (cand_pos < isr_pos);

endmodule

// File: rtl/irq_rot_state.sv
// In-service register and rotation base with strobe precedence.
module irq_rot_state #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ack_i,
  input  logic          win_valid_i,
  input  logic [LW-1:0] win_line_i,
  input  logic          auto_eoi_i,
  input  logic          rot_aeoi_i,
  input  logic          eoi_i,
  input  logic          spec_eoi_i,
  input  logic [LW-1:0] spec_line_i,
  input  logic          eoi_rot_i,
  input  logic          prio_set_i,
  input  logic [LW-1:0] prio_line_i,
  output logic [N-1:0]  isr_o,
  output logic [LW-1:0] base_o
);
  import irq_rot_pkg::*;

  logic [N-1:0]  isr_q;
  logic [LW-1:0] base_q;
  logic          top_any;
  logic [LW:0]   top_pos;
  logic [LW-1:0] top_line;
  logic [N-1:0]  clr_v;
  logic [N-1:0]  set_v;
  logic [N-1:0]  isr_n;
  logic [LW-1:0] base_n;
  base_src_e     base_sel;
  logic          grant;

  // Best in-service line, used by the highest-priority end-of-interrupt
  irq_rot_find #(.N(N), .LW(LW)) u_find_top (
    .vec_i  (isr_q),
    .base_i (base_q),
    .any_o  (top_any),
    .pos_o  (top_pos),
    .line_o (top_line)
  );

  logic unused_pos;
  assign unused_pos = top_pos[LW];

  assign grant = ack_i && win_valid_i;

  always_comb begin
    clr_v = '0;
    if (eoi_i && top_any) clr_v[top_line]    = 1'b1;
    if (spec_eoi_i)       clr_v[spec_line_i] = 1'b1;
    set_v = '0;
    if (grant && !auto_eoi_i) set_v[win_line_i] = 1'b1;
    isr_n = (isr_q & ~clr_v) | set_v;
  end

  always_comb begin
    if (grant && auto_eoi_i && rot_aeoi_i)  base_sel = BASE_ACK;
    else if (eoi_i && top_any && eoi_rot_i) base_sel = BASE_EOI;
    else if (spec_eoi_i && eoi_rot_i)       base_sel = BASE_SEOI;
    else if (prio_set_i)                    base_sel = BASE_PRIO;
    else                                    base_sel = BASE_HOLD;
  end

  always_comb begin
    unique case (base_sel)
      BASE_ACK:  base_n = win_line_i + 1'b1;
      BASE_EOI:  base_n = top_line + 1'b1;
      BASE_SEOI: base_n = spec_line_i + 1'b1;
      BASE_PRIO: base_n = prio_line_i + 1'b1;
      default:   base_n = base_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q  <= '0;
      base_q <= '0;
    end else begin
      isr_q  <= isr_n;
      base_q <= base_n;
    end
  end

  assign isr_o  = isr_q;
  assign base_o = base_q;

endmodule

// File: rtl/irq_rot_resolver.sv
module irq_rot_resolver #(
  parameter int   N_LINES     = 8,
  parameter int   VEC_W       = 8,
  parameter int   CASC_LINE   = 2,
  parameter bit   CASC_MASTER = 1'b1,
  localparam int  LW          = $clog2(N_LINES),
  localparam int  VB_W        = VEC_W - LW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] pend_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic [VB_W-1:0]    vec_base_i,
  input  logic               auto_eoi_i,
  input  logic               rot_aeoi_i,
  input  logic               sfnm_i,
  input  logic               ack_i,
  input  logic               eoi_i,
  input  logic               spec_eoi_i,
  input  logic [LW-1:0]      spec_line_i,
  input  logic               eoi_rot_i,
  input  logic               prio_set_i,
  input  logic [LW-1:0]      prio_line_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               vec_valid_o,
  output logic [N_LINES-1:0] isr_o,
  output logic [LW-1:0]      rot_base_o
);

  localparam logic [LW-1:0] SPUR_LINE = LW'(N_LINES - 1);

  logic [N_LINES-1:0] isr_w;
  logic [LW-1:0]      base_w;
  logic               req_w;
  logic [LW-1:0]      win_line_w;
  logic               irq_q;
  logic [VEC_W-1:0]   vec_q;
  logic               vld_q;

  irq_rot_arb #(
    .N(N_LINES), .LW(LW), .CASC_LINE(CASC_LINE), .CASC_MASTER(CASC_MASTER)
  ) u_arb (
    .pend_i (pend_i),
    .mask_i (mask_i),
    .isr_i  (isr_w),
    .base_i (base_w),
    .sfnm_i (sfnm_i),
    .req_o  (req_w),
    .line_o (win_line_w)
  );

  irq_rot_state #(.N(N_LINES), .LW(LW)) u_state (
    .clk         (clk),
    .rst         (rst),
    .ack_i       (ack_i),
    .win_valid_i (req_w),
    .win_line_i  (win_line_w),
    .auto_eoi_i  (auto_eoi_i),
    .rot_aeoi_i  (rot_aeoi_i),
    .eoi_i       (eoi_i),
    .spec_eoi_i  (spec_eoi_i),
    .spec_line_i (spec_line_i),
    .eoi_rot_i   (eoi_rot_i),
    .prio_set_i  (prio_set_i),
    .prio_line_i (prio_line_i),
    .isr_o       (isr_w),
    .base_o      (base_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      vec_q <= '0;
      vld_q <= 1'b0;
    end else begin
      irq_q <= req_w;
      vld_q <= ack_i;
      if (ack_i) vec_q <= {vec_base_i, (req_w ? win_line_w : SPUR_LINE)};
    end
  end

  assign irq_o       = irq_q;
  assign vec_o       = vec_q;
  assign vec_valid_o = vld_q;
  assign isr_o       = isr_w;
  assign rot_base_o  = base_w;

endmodule

// File: rtl/irq_rot_resolver_chk.sv
module irq_rot_resolver_chk #(
  parameter int N_LINES = 8,
  parameter int VEC_W   = 8,
  parameter int LW      = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [N_LINES-1:0] pend_i,
  input logic [N_LINES-1:0] mask_i,
  input logic [VEC_W-LW-1:0] vec_base_i,
  input logic               auto_eoi_i,
  input logic               ack_i,
  input logic               eoi_i,
  input logic               spec_eoi_i,
  input logic               irq_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic               vec_valid_o,
  input logic [N_LINES-1:0] isr_o,
  input logic [LW-1:0]      rot_base_o
);

  logic past_rst;
  always_ff @(posedge clk) past_rst <= rst;

  // R1: state is clear in the first cycle after reset
  always_ff @(posedge clk) begin
    if (past_rst && !rst) begin
      assert_reset_clear_R1: assert (isr_o == '0 && rot_base_o == '0 && !irq_o && !vec_valid_o)
        else $error("reset state not clear");
    end
  end

  assert_irq_needs_cand_R2: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|(pend_i & ~mask_i)));

  assert_ack_one_bit_R6: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !auto_eoi_i) |=> ($countones(isr_o) <= $countones($past(isr_o)) + 1));

  assert_vec_base_R6: assert property (@(posedge clk) disable iff (rst)
    ack_i |=> (vec_valid_o && vec_o[VEC_W-1:LW] == $past(vec_base_i)));

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    !ack_i |=> !vec_valid_o);

  assert_aeoi_keeps_isr_R8: assert property (@(posedge clk) disable iff (rst)
    (ack_i && auto_eoi_i && !eoi_i && !spec_eoi_i) |=> (isr_o == $past(isr_o)));

  assert_eoi_drops_one_R9: assert property (@(posedge clk) disable iff (rst)
    (eoi_i && !ack_i && !spec_eoi_i && (|isr_o)) |=>
      ($countones(isr_o) + 1 == $countones($past(isr_o))));

endmodule

bind irq_rot_resolver irq_rot_resolver_chk #(
  .N_LINES(N_LINES), .VEC_W(VEC_W), .LW(LW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pend_i      (pend_i),
  .mask_i      (mask_i),
  .vec_base_i  (vec_base_i),
  .auto_eoi_i  (auto_eoi_i),
  .ack_i       (ack_i),
  .eoi_i       (eoi_i),
  .spec_eoi_i  (spec_eoi_i),
  .irq_o       (irq_o),
  .vec_o       (vec_o),
  .vec_valid_o (vec_valid_o),
  .isr_o       (isr_o),
  .rot_base_o  (rot_base_o)
);

// File: tb/irq_rot_resolver_tb.sv
`timescale 1ns/1ps
module irq_rot_resolver_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pend_i = '0, mask_i = '0;
  logic [4:0] vec_base_i = '0;
  logic       auto_eoi_i = 0, rot_aeoi_i = 0, sfnm_i = 0;
  logic       ack_i = 0, eoi_i = 0, spec_eoi_i = 0, eoi_rot_i = 0, prio_set_i = 0;
  logic [2:0] spec_line_i = '0, prio_line_i = '0;
  logic       irq_o, vec_valid_o;
  logic [7:0] vec_o, isr_o;
  logic [2:0] rot_base_o;

  int errs = 0, checks = 0;
  logic [7:0] m_isr = '0;
  logic [2:0] m_base = '0;
  logic       e_irq, e_vld;
  logic [7:0] e_vec = '0;

  always #5 clk = ~clk;

  irq_rot_resolver u_dut (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // position of best set bit relative to base, 8 when empty
  function automatic int best_pos(input logic [7:0] v, input logic [2:0] b);
    for (int p = 0; p < 8; p++) if (v[(p + b) % 8]) return p;
    return 8;
  endfunction

  task automatic step(input string tag);
    int cp, ip, ep;
    logic [7:0] cand, icmp, clr, setv;
    logic req;
    logic [2:0] wl, el, nb;
    cand = pend_i & ~mask_i;
    cp   = best_pos(cand, m_base);
    icmp = m_isr;
    if (sfnm_i) icmp[2] = 1'b0;
    ip   = best_pos(icmp, m_base);
    req  = (cand != 0) && (cp < ip);
    wl   = 3'(cp + m_base);
    e_irq = req;
    e_vld = ack_i;
    if (ack_i) e_vec = {vec_base_i, (req ? wl : 3'd7)};
    clr = '0; setv = '0;
    ep = best_pos(m_isr, m_base);
    el = 3'(ep + m_base);
    if (eoi_i && m_isr != 0) clr[el] = 1'b1;
    if (spec_eoi_i) clr[spec_line_i] = 1'b1;
    if (ack_i && req && !auto_eoi_i) setv[wl] = 1'b1;
    nb = m_base;
    if (ack_i && req && auto_eoi_i && rot_aeoi_i) nb = wl + 3'd1;
    else if (eoi_i && m_isr != 0 && eoi_rot_i)    nb = el + 3'd1;
    else if (spec_eoi_i && eoi_rot_i)             nb = spec_line_i + 3'd1;
    else if (prio_set_i)                          nb = prio_line_i + 3'd1;
    m_isr  = (m_isr & ~clr) | setv;
    m_base = nb;
    @(posedge clk);
    @(negedge clk);
    chk(irq_o == e_irq, tag, "irq", irq_o, e_irq);
    chk(isr_o == m_isr, tag, "isr", isr_o, m_isr);
    chk(rot_base_o == m_base, tag, "base", rot_base_o, m_base);
    chk(vec_valid_o == e_vld, tag, "vec_valid", vec_valid_o, e_vld);
    if (e_vld) chk(vec_o == e_vec, tag, "vec", vec_o, e_vec);
    ack_i = 0; eoi_i = 0; spec_eoi_i = 0; prio_set_i = 0;
  endtask

  initial begin
    #1_000_000;
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk(isr_o == 0 && rot_base_o == 0 && !irq_o && !vec_valid_o, "R1", "reset",
        {isr_o, rot_base_o}, 0);
    vec_base_i = 5'h0b;
    // R2: nothing pending, then pending but masked
    step("R2");
    pend_i = 8'h10; mask_i = 8'h10; step("R2");
    // R3/R6: two lines, lower line wins and goes in service
    pend_i = 8'h28; mask_i = 0; step("R3");
    ack_i = 1; step("R6");
    // R4: worse and equal levels stay quiet, better raises
    pend_i = 8'h20; step("R4");
    pend_i = 8'h08; step("R4");
    pend_i = 8'h09; step("R4");
    // R9: clear best in-service with rotate
    pend_i = 0; eoi_i = 1; eoi_rot_i = 1; step("R9");
    eoi_i = 1; step("R9");
    eoi_rot_i = 0;
    // R11: set priority, then rotated ordering
    prio_line_i = 3'd4; prio_set_i = 1; step("R11");
    pend_i = 8'h11; step("R3");
    ack_i = 1; step("R3");
    // R7: spurious acknowledge
    pend_i = 0; ack_i = 1; step("R7");
    // R10: specific clear with rotate
    spec_line_i = 3'd0; spec_eoi_i = 1; eoi_rot_i = 1; step("R10");
    eoi_rot_i = 0;
    // R5: cascade line in service, interrupts again only with the option
    pend_i = 8'h04; ack_i = 1; step("R5");
    step("R5");
    sfnm_i = 1; step("R5");
    // R12: acknowledge and end-of-interrupt together on the cascade bit
    ack_i = 1; eoi_i = 1; eoi_rot_i = 1; step("R12");
    eoi_rot_i = 0; sfnm_i = 0; pend_i = 0;
    spec_line_i = 3'd2; spec_eoi_i = 1; step("R10");
    // R8: automatic end-of-interrupt with rotation
    auto_eoi_i = 1; rot_aeoi_i = 1; pend_i = 8'h81; ack_i = 1; step("R8");
    ack_i = 1; step("R8");
    auto_eoi_i = 0; rot_aeoi_i = 0;
    // R12: rotation precedence, ack against set-priority
    auto_eoi_i = 1; rot_aeoi_i = 1; ack_i = 1; prio_set_i = 1; prio_line_i = 3'd6;
    step("R12");
    auto_eoi_i = 0; rot_aeoi_i = 0;
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      pend_i      = 8'($urandom);
      mask_i      = 8'($urandom & $urandom);
      vec_base_i  = 5'($urandom);
      ack_i       = ($urandom % 3) == 0;
      eoi_i       = ($urandom % 5) == 0;
      spec_eoi_i  = ($urandom % 8) == 0;
      spec_line_i = 3'($urandom);
      eoi_rot_i   = $urandom % 2;
      prio_set_i  = ($urandom % 16) == 0;
      prio_line_i = 3'($urandom);
      if (i % 256 == 0) begin
        auto_eoi_i = ($urandom % 4) == 0;
        rot_aeoi_i = $urandom % 2;
        sfnm_i     = $urandom % 2;
      end
      step("R3/R4/R12");
    end
    // R1: reset mid-run
    rst = 1; @(posedge clk); @(negedge clk); rst = 0;
    m_isr = 0; m_base = 0;
    chk(isr_o == 0 && rot_base_o == 0 && !irq_o && !vec_valid_o, "R1", "re-reset",
        {isr_o, rot_base_o}, 0);
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule